// File: doc/BRIEF.md
# Multi-Consumer Two-Dimensional Line Buffer Pool

This block keeps recent image rows on chip so that stencil kernels can fetch neighbouring pixels again and again without a trip to external memory. It holds a small pool of logical line buffers. Each one acts as a two-dimensional FIFO: rows go in at one end in raster order and leave at the other once every reader is finished with them. A producer fills a buffer a few pixels at a time. Each consumer takes a rectangular window of whole rows and a column slice whenever it is ready, so the write unit and the read shape do not depend on each other.

The pool has `NUM_KLB` kernel buffers, all fed from one shared producer port that carries a buffer select. One further buffer is set aside for DMA traffic. It has a write port of its own, so a DMA load can go on in the same cycle as kernel writes. Every buffer keeps a write pointer and one read pointer per consumer. A static mask states which consumers a buffer serves. When the slowest registered consumer of a buffer still needs every row slot, the producer is held off.

Storage is circular over `DEPTH` row slots, and `DEPTH` must be a power of two. A consumer names a buffer, a window height, a first column and whether to step past its oldest row. One cycle after the request, the answer comes back as an acknowledge strobe and the window data.

Top module: `line_buf_pool`

## Requirements
- R1: A write group carries `GRP_PIX` pixels, with pixel p in `kWrData[p*PIX_W +: PIX_W]` (the DMA port is laid out the same way). Group g of a row lands in columns `g*GRP_PIX` upward. A row becomes readable only after its last group (group `GRP_PER_ROW-1`) is accepted, and an accepted group that is not the last one does not move the write pointer.
- R2: A granted read returns, in `rdData[c][r]`, the row that lies r rows beyond consumer c's read pointer. Row 0 is the oldest unconsumed row.
- R3: Window row r carries `RD_PIX` pixels, and pixel k holds column `rdCol+k`. Columns at or beyond `ROW_PIX`, and rows with r at or beyond `rdRows`, read as zero.
- R4: A request is acknowledged one cycle after it is made, on `rdAck[c]`, only when all of the following hold: the selected buffer exists, the consumer is registered for it, `rdRows` is at least 1, and `rdRows` does not exceed the number of complete rows ahead of that consumer.
- R5: A granted request with `rdAdv` high moves the consumer's read pointer on by one row. Any other request leaves the pointer where it is.
- R6: The producer ready for a buffer is low while some registered consumer has `DEPTH` complete rows unconsumed. A write offered while the ready is low has no effect.
- R7: A row slot is released only when every registered consumer has moved past it. One consumer advancing while another has not does not lift the stall.
- R8: Row storage wraps modulo `DEPTH`. Windows that straddle the wrap return rows in age order.
- R9: An unregistered consumer is never granted and never holds back the producer. Once it is registered, its pointer starts at the next row to be completed.
- R10: The DMA buffer has index `NUM_KLB`. It is written only through its own port, which may accept a group in the same cycle as the kernel port. When `kWrSel` is `NUM_KLB` or higher, `kWrReady` is low and the write has no effect.
- R11: After reset every buffer is empty, both producer readies are high and no acknowledge is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| consMask | input | NUM_LB x NUM_CONS | Consumer registration per buffer |
| kWrValid | input | 1 | Kernel producer offers a group |
| kWrSel | input | SEL_W | Target kernel buffer |
| kWrData | input | GRP_PIX*PIX_W | Kernel group pixels |
| kWrReady | output | 1 | Selected kernel buffer can accept |
| dWrValid | input | 1 | DMA port offers a group |
| dWrData | input | GRP_PIX*PIX_W | DMA group pixels |
| dWrReady | output | 1 | DMA buffer can accept |
| rdReq | input | NUM_CONS | Read request per consumer |
| rdSel | input | NUM_CONS x SEL_W | Buffer selected by each consumer |
| rdRows | input | NUM_CONS x ROWS_W | Window height in rows |
| rdCol | input | NUM_CONS x COL_W | First column of the slice |
| rdAdv | input | NUM_CONS | Step past the oldest row when granted |
| rdAck | output | NUM_CONS | Request granted (one cycle later) |
| rdData | output | NUM_CONS x DEPTH x RD_PIX x PIX_W | Window pixels |

## Verification
The bench uses the package defaults: two kernel buffers plus the DMA buffer, two consumers, four row slots, eight-pixel rows written two pixels at a time, and three-pixel read slices. Rows this short let the bench sweep every window height against every column start, including the starts that run past the row end. Four slots take only a handful of rows to fill, so the bench reaches stalls, partial release by one consumer and several passes round the wrap within a few hundred cycles. The pixel values it expects come from a formula over buffer, absolute row and column, so a row read from the wrong slot or the wrong pass shows up at once.

// File: rtl/line_buf_pkg.sv
package line_buf_pkg;
  localparam int PIX_W       = 8;
  localparam int GRP_PIX     = 2;
  localparam int GRP_PER_ROW = 4;
  localparam int DEPTH       = 4;   // power of two
  localparam int NUM_KLB     = 2;
  localparam int NUM_CONS    = 2;
  localparam int RD_PIX      = 3;

  localparam int ROW_PIX = GRP_PIX * GRP_PER_ROW;
  localparam int NUM_LB  = NUM_KLB + 1;
  localparam int DMA_IDX = NUM_KLB;
  localparam int SEL_W   = $clog2(NUM_LB);
  localparam int SLOT_W  = $clog2(DEPTH);
  localparam int PTR_W   = SLOT_W + 1;
  localparam int ROWS_W  = $clog2(DEPTH + 1);
  localparam int GRP_W   = $clog2(GRP_PER_ROW);
  localparam int COL_W   = $clog2(ROW_PIX);
  localparam int GRPD_W  = GRP_PIX * PIX_W;

  typedef struct packed {
    logic                               kWrEn;
    logic [SEL_W-1:0]                   kWrBuf;
    logic [SLOT_W-1:0]                  kWrSlot;
    logic [GRP_W-1:0]                   kWrGrp;
    logic                               dWrEn;
    logic [SLOT_W-1:0]                  dWrSlot;
    logic [GRP_W-1:0]                   dWrGrp;
    logic [NUM_CONS-1:0]                rdEn;
    logic [NUM_CONS-1:0][SEL_W-1:0]     rdBuf;
    logic [NUM_CONS-1:0][SLOT_W-1:0]    rdSlot;
    logic [NUM_CONS-1:0][ROWS_W-1:0]    rdRows;
    logic [NUM_CONS-1:0][COL_W-1:0]     rdCol;
  } lbStrobe_t;
endpackage

// File: rtl/line_buf_ctrl.sv
module line_buf_ctrl
  import line_buf_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_LB-1:0][NUM_CONS-1:0] consMask,
  input  logic                            kWrValid,
  input  logic [SEL_W-1:0]                kWrSel,
  output logic                            kWrReady,
  input  logic                            dWrValid,
  output logic                            dWrReady,
  input  logic [NUM_CONS-1:0]             rdReq,
  input  logic [NUM_CONS-1:0][SEL_W-1:0]  rdSel,
  input  logic [NUM_CONS-1:0][ROWS_W-1:0] rdRows,
  input  logic [NUM_CONS-1:0][COL_W-1:0]  rdCol,
  input  logic [NUM_CONS-1:0]             rdAdv,
  output logic [NUM_CONS-1:0]             rdAck,
  output lbStrobe_t                       strobe
);
  logic [PTR_W-1:0] wrPtr    [NUM_LB];
  logic [PTR_W-1:0] wrPtrNxt [NUM_LB];
  logic [GRP_W-1:0] wrGrp    [NUM_LB];
  logic [PTR_W-1:0] rdPtr    [NUM_LB][NUM_CONS];
  logic [PTR_W-1:0] occ      [NUM_LB][NUM_CONS];
  logic             grantMat [NUM_LB][NUM_CONS];
  logic             full     [NUM_LB];
  logic             wrAcc    [NUM_LB];
  logic             rowDone  [NUM_LB];
  logic [NUM_CONS-1:0] rdGo;

  for (genvar b = 0; b < NUM_LB; b++) begin : g_lb
    for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
      assign occ[b][c] = wrPtr[b] - rdPtr[b][c];
      assign grantMat[b][c] = rdReq[c] && (rdSel[c] == SEL_W'(b)) && consMask[b][c]
                              && (rdRows[c] != '0)
                              && (32'(rdRows[c]) <= 32'(occ[b][c]));

      always_ff @(posedge clk) begin
        if (!rstN)                            rdPtr[b][c] <= '0;
        else if (!consMask[b][c])             rdPtr[b][c] <= wrPtrNxt[b];
        else if (grantMat[b][c] && rdAdv[c])  rdPtr[b][c] <= rdPtr[b][c] + PTR_W'(1);
      end

      // R6
      occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
        consMask[b][c] |-> (occ[b][c] <= PTR_W'(DEPTH)));
      // R5
      ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (consMask[b][c] && !(grantMat[b][c] && rdAdv[c])) |=> $stable(rdPtr[b][c]));
    end

    always_comb begin
      full[b] = 1'b0;
      for (int c = 0; c < NUM_CONS; c++)
        if (consMask[b][c] && (occ[b][c] == PTR_W'(DEPTH))) full[b] = 1'b1;
    end

    if (b == DMA_IDX) begin : g_dma
      assign wrAcc[b] = dWrValid && !full[b];
    end else begin : g_krn
      assign wrAcc[b] = kWrValid && (kWrSel == SEL_W'(b)) && !full[b];
    end

    assign rowDone[b]  = wrAcc[b] && (wrGrp[b] == GRP_W'(GRP_PER_ROW - 1));
    assign wrPtrNxt[b] = wrPtr[b] + PTR_W'(rowDone[b]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrGrp[b] <= '0;
        wrPtr[b] <= '0;
      end else begin
        if (wrAcc[b]) wrGrp[b] <= rowDone[b] ? '0 : wrGrp[b] + GRP_W'(1);
        wrPtr[b] <= wrPtrNxt[b];
      end
    end

    // R1
    wr_row_chk: assert property (@(posedge clk) disable iff (!rstN)
      !rowDone[b] |=> $stable(wrPtr[b]));
  end

  always_comb begin
    kWrReady = 1'b0;
    for (int b = 0; b < NUM_KLB; b++)
      if (kWrSel == SEL_W'(b)) kWrReady = !full[b];
  end
  assign dWrReady = !full[DMA_IDX];

  always_comb begin
    strobe         = '0;
    strobe.kWrEn   = kWrValid && kWrReady;
    strobe.kWrBuf  = kWrSel;
    strobe.dWrEn   = wrAcc[DMA_IDX];
    strobe.dWrSlot = wrPtr[DMA_IDX][SLOT_W-1:0];
    strobe.dWrGrp  = wrGrp[DMA_IDX];
    strobe.rdBuf   = rdSel;
    strobe.rdRows  = rdRows;
    strobe.rdCol   = rdCol;
    for (int b = 0; b < NUM_KLB; b++)
      if (kWrSel == SEL_W'(b)) begin
        strobe.kWrSlot = wrPtr[b][SLOT_W-1:0];
        strobe.kWrGrp  = wrGrp[b];
      end
    for (int c = 0; c < NUM_CONS; c++) begin
      rdGo[c] = 1'b0;
      for (int b = 0; b < NUM_LB; b++) begin
        rdGo[c] = rdGo[c] | grantMat[b][c];
        if (rdSel[c] == SEL_W'(b)) strobe.rdSlot[c] = rdPtr[b][c][SLOT_W-1:0];
      end
    end
    strobe.rdEn = rdGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdAck <= '0;
    else       rdAck <= rdGo;
  end

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_ack
    // R4
    ack_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      rdAck[c] |-> $past(rdReq[c]));
  end
endmodule

// File: rtl/line_buf_dpath.sv
module line_buf_dpath
  import line_buf_pkg::*;
(
  input  logic                                             clk,
  input  logic                                             rstN,
  input  lbStrobe_t                                        strobe,
  input  logic [GRPD_W-1:0]                                kWrData,
  input  logic [GRPD_W-1:0]                                dWrData,
  output logic [NUM_CONS-1:0][DEPTH-1:0][RD_PIX-1:0][PIX_W-1:0] rdData
);
  logic [PIX_W-1:0] mem [NUM_LB][DEPTH][ROW_PIX];
  logic [NUM_CONS-1:0][DEPTH-1:0][RD_PIX-1:0][PIX_W-1:0] winNxt;

  always_ff @(posedge clk) begin
    for (int p = 0; p < GRP_PIX; p++) begin
      if (strobe.kWrEn)
        mem[strobe.kWrBuf][strobe.kWrSlot][COL_W'(int'(strobe.kWrGrp) * GRP_PIX + p)]
          <= kWrData[p*PIX_W +: PIX_W];
      if (strobe.dWrEn)
        mem[DMA_IDX][strobe.dWrSlot][COL_W'(int'(strobe.dWrGrp) * GRP_PIX + p)]
          <= dWrData[p*PIX_W +: PIX_W];
    end
  end

  always_comb begin
    winNxt = '0;
    for (int c = 0; c < NUM_CONS; c++)
      for (int r = 0; r < DEPTH; r++)
        for (int k = 0; k < RD_PIX; k++)
          if (strobe.rdEn[c] && (r < int'(strobe.rdRows[c]))
              && (int'(strobe.rdCol[c]) + k < ROW_PIX))
            winNxt[c][r][k] = mem[strobe.rdBuf[c]]
                                 [SLOT_W'(int'(strobe.rdSlot[c]) + r)]
                                 [COL_W'(int'(strobe.rdCol[c]) + k)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else
      for (int c = 0; c < NUM_CONS; c++)
        if (strobe.rdEn[c]) rdData[c] <= winNxt[c];
  end

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_rc
    for (genvar r = 0; r < DEPTH; r++) begin : g_rr
      // R3
      tail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.rdEn[c] && (32'(strobe.rdRows[c]) <= r)) |=> (rdData[c][r] == '0));
    end
  end
endmodule

// File: rtl/line_buf_pool.sv
module line_buf_pool
  import line_buf_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_LB-1:0][NUM_CONS-1:0] consMask,
  input  logic                            kWrValid,
  input  logic [SEL_W-1:0]                kWrSel,
  input  logic [GRPD_W-1:0]               kWrData,
  output logic                            kWrReady,
  input  logic                            dWrValid,
  input  logic [GRPD_W-1:0]               dWrData,
  output logic                            dWrReady,
  input  logic [NUM_CONS-1:0]             rdReq,
  input  logic [NUM_CONS-1:0][SEL_W-1:0]  rdSel,
  input  logic [NUM_CONS-1:0][ROWS_W-1:0] rdRows,
  input  logic [NUM_CONS-1:0][COL_W-1:0]  rdCol,
  input  logic [NUM_CONS-1:0]             rdAdv,
  output logic [NUM_CONS-1:0]             rdAck,
  output logic [NUM_CONS-1:0][DEPTH-1:0][RD_PIX-1:0][PIX_W-1:0] rdData
);
  lbStrobe_t strobe;

  line_buf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .consMask(consMask),
    .kWrValid(kWrValid), .kWrSel(kWrSel), .kWrReady(kWrReady),
    .dWrValid(dWrValid), .dWrReady(dWrReady),
    .rdReq(rdReq), .rdSel(rdSel), .rdRows(rdRows), .rdCol(rdCol), .rdAdv(rdAdv),
    .rdAck(rdAck), .strobe(strobe)
  );

  line_buf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .kWrData(kWrData), .dWrData(dWrData), .rdData(rdData)
  );
endmodule

// File: tb/line_buf_pool_tb.sv
module line_buf_pool_tb;
  import line_buf_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_LB-1:0][NUM_CONS-1:0] consMask;
  logic kWrValid = 1'b0;
  logic [SEL_W-1:0] kWrSel = '0;
  logic [GRPD_W-1:0] kWrData = '0;
  logic kWrReady;
  logic dWrValid = 1'b0;
  logic [GRPD_W-1:0] dWrData = '0;
  logic dWrReady;
  logic [NUM_CONS-1:0] rdReq = '0;
  logic [NUM_CONS-1:0][SEL_W-1:0] rdSel = '0;
  logic [NUM_CONS-1:0][ROWS_W-1:0] rdRows = '0;
  logic [NUM_CONS-1:0][COL_W-1:0] rdCol = '0;
  logic [NUM_CONS-1:0] rdAdv = '0;
  logic [NUM_CONS-1:0] rdAck;
  logic [NUM_CONS-1:0][DEPTH-1:0][RD_PIX-1:0][PIX_W-1:0] rdData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  int mWr [NUM_LB];
  int mGrp [NUM_LB];
  int mRd [NUM_LB][NUM_CONS];

  line_buf_pool u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !done) begin
      failures++;
      $display("FAIL R11 watchdog expired actual=%0d expected<%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [PIX_W-1:0] pix(int b, int row, int col);
    return PIX_W'(b * 97 + row * 16 + col + 1);
  endfunction

  function automatic bit expFree(int b);
    for (int c = 0; c < NUM_CONS; c++)
      if (consMask[b][c] && (mWr[b] - mRd[b][c] >= DEPTH)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [GRPD_W-1:0] grpData(int b);
    logic [GRPD_W-1:0] d;
    for (int p = 0; p < GRP_PIX; p++)
      d[p*PIX_W +: PIX_W] = pix(b, mWr[b], mGrp[b] * GRP_PIX + p);
    return d;
  endfunction

  task automatic bumpGrp(int b);
    if (mGrp[b] == GRP_PER_ROW - 1) begin mGrp[b] = 0; mWr[b]++; end
    else mGrp[b]++;
  endtask

  // write n groups to buffer b through its proper port (R1/R10)
  task automatic putGroups(int b, int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (b == DMA_IDX) begin dWrValid = 1'b1; dWrData = grpData(b); end
      else begin kWrValid = 1'b1; kWrSel = SEL_W'(b); kWrData = grpData(b); end
      #1;
      check((b == DMA_IDX ? dWrReady : kWrReady) == expFree(b), req, "producer ready",
            int'(b == DMA_IDX ? dWrReady : kWrReady), int'(expFree(b)));
      @(posedge clk);
      #1 kWrValid = 1'b0; dWrValid = 1'b0;
      bumpGrp(b);
    end
  endtask

  task automatic putRow(int b, string req);
    putGroups(b, GRP_PER_ROW, req);
  endtask

  // offer a junk group that must be refused (R6/R10)
  task automatic tryStall(int sel, bit dma, string req);
    @(negedge clk);
    if (dma) begin dWrValid = 1'b1; dWrData = '1; end
    else begin kWrValid = 1'b1; kWrSel = SEL_W'(sel); kWrData = '1; end
    #1;
    check((dma ? dWrReady : kWrReady) == 1'b0, req, "ready while blocked",
          int'(dma ? dWrReady : kWrReady), 0);
    @(posedge clk);
    #1 kWrValid = 1'b0; dWrValid = 1'b0;
  endtask

  task automatic readChk(int c, int b, int n, int col, bit adv, string req);
    bit expG;
    int bad;
    int badAct;
    int badExp;
    expG = (b < NUM_LB) && (n >= 1);
    if (b < NUM_LB) expG = expG && consMask[b][c] && (n <= mWr[b] - mRd[b][c]);
    @(negedge clk);
    rdReq[c] = 1'b1; rdSel[c] = SEL_W'(b); rdRows[c] = ROWS_W'(n);
    rdCol[c] = COL_W'(col); rdAdv[c] = adv;
    @(posedge clk);
    #1 rdReq[c] = 1'b0;
    @(negedge clk);
    check(rdAck[c] == expG, req, $sformatf("ack c%0d b%0d n%0d", c, b, n),
          int'(rdAck[c]), int'(expG));
    if (expG) begin
      bad = 0; badAct = 0; badExp = 0;
      for (int r = 0; r < DEPTH; r++)
        for (int k = 0; k < RD_PIX; k++) begin
          logic [PIX_W-1:0] e;
          e = ((r < n) && (col + k < ROW_PIX)) ? pix(b, mRd[b][c] + r, col + k) : '0;
          if (rdData[c][r][k] != e && bad == 0) begin
            bad = 1; badAct = int'(rdData[c][r][k]); badExp = int'(e);
          end
        end
      check(bad == 0, req, $sformatf("window c%0d b%0d n%0d col%0d", c, b, n, col),
            badAct, badExp);
      if (adv) mRd[b][c]++;
    end
  endtask

  initial begin
    for (int b = 0; b < NUM_LB; b++) begin
      mWr[b] = 0; mGrp[b] = 0;
      for (int c = 0; c < NUM_CONS; c++) mRd[b][c] = 0;
    end
    consMask[0] = 2'b11;
    consMask[1] = 2'b01;
    consMask[2] = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R11 reset state
    #1;
    check(kWrReady == 1'b1, "R11", "kernel ready after reset", int'(kWrReady), 1);
    check(dWrReady == 1'b1, "R11", "dma ready after reset", int'(dWrReady), 1);
    check(rdAck == '0, "R11", "no ack after reset", int'(rdAck), 0);

    // R4 empty buffer, R1 partial row not readable
    readChk(0, 0, 1, 0, 0, "R4");
    putGroups(0, 2, "R1");
    readChk(0, 0, 1, 0, 0, "R1");
    putGroups(0, GRP_PER_ROW - 2, "R1");

    // R3 column sweep over one row, including past-end columns
    for (int col = 0; col < ROW_PIX; col++) readChk(0, 0, 1, col, 0, "R3");
    readChk(0, 0, 2, 0, 0, "R4");
    readChk(1, 0, 0, 0, 0, "R4");

    // fill, then R6 stall
    for (int i = 0; i < DEPTH - 1; i++) putRow(0, "R6");
    tryStall(0, 0, "R6");

    // R2/R3 full window sweep
    for (int n = 1; n <= DEPTH; n++)
      for (int col = 0; col < ROW_PIX; col++) readChk(1, 0, n, col, 0, "R2");

    // R7 partial release keeps the stall
    readChk(0, 0, 1, 0, 1, "R5");
    tryStall(0, 0, "R7");
    readChk(1, 0, 2, 3, 1, "R7");
    putRow(0, "R7");

    // R8 several passes round the wrap
    for (int i = 0; i < 6; i++) begin
      readChk(0, 0, 1, 0, 1, "R8");
      readChk(1, 0, 1, 0, 1, "R8");
      putRow(0, "R8");
    end
    for (int n = 1; n <= DEPTH; n++)
      for (int col = 0; col < ROW_PIX; col += 2) readChk(0, 0, n, col, 0, "R8");

    // R9 unregistered consumer on buffer 1
    readChk(1, 1, 1, 0, 0, "R9");
    for (int i = 0; i < DEPTH; i++) putRow(1, "R9");
    tryStall(1, 0, "R9");
    readChk(1, 1, 1, 0, 1, "R9");
    tryStall(1, 0, "R9");
    readChk(0, 1, 2, 1, 1, "R9");
    putRow(1, "R9");

    // R10 kernel and dma writes in the same cycle
    readChk(0, 0, 1, 0, 1, "R10");
    readChk(1, 0, 1, 0, 1, "R10");
    for (int g = 0; g < GRP_PER_ROW; g++) begin
      @(negedge clk);
      kWrValid = 1'b1; kWrSel = SEL_W'(0); kWrData = grpData(0);
      dWrValid = 1'b1; dWrData = grpData(DMA_IDX);
      #1;
      check(kWrReady == 1'b1 && dWrReady == 1'b1, "R10", "both ports ready",
            int'({kWrReady, dWrReady}), 3);
      @(posedge clk);
      #1 kWrValid = 1'b0; dWrValid = 1'b0;
      bumpGrp(0); bumpGrp(DMA_IDX);
    end
    for (int col = 0; col < ROW_PIX; col++) readChk(1, DMA_IDX, 1, col, 0, "R10");
    readChk(0, 0, DEPTH, 2, 0, "R10");
    readChk(0, DMA_IDX, 1, 0, 0, "R9");

    // R10 kernel port cannot reach the dma buffer or a missing index
    tryStall(DMA_IDX, 0, "R10");
    tryStall(NUM_LB, 0, "R10");
    readChk(1, DMA_IDX, 2, 0, 0, "R10");
    readChk(0, NUM_LB, 1, 0, 0, "R4");

    // R9 registration starts at the next completed row
    @(negedge clk);
    consMask[DMA_IDX][0] = 1'b1;
    mRd[DMA_IDX][0] = mWr[DMA_IDX];
    readChk(0, DMA_IDX, 1, 0, 0, "R9");
    putRow(DMA_IDX, "R9");
    readChk(0, DMA_IDX, 1, 1, 0, "R9");
    readChk(1, DMA_IDX, 2, 0, 0, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule